// File: doc/BRIEF.md
# Attribute-Colour Pixel Serializer

This block turns screen bytes fetched from memory into a line of 640 pixel slots on a three-wire RGB output. Each bitmap byte gives eight pixels, most significant bit first, and each pixel is held for one, two or three clock cycles according to the horizontal scale. At x3 only 26 whole byte columns fit in a line, so the last 16 slots are sent as black.

In the one-bit-per-pixel colour modes the block also reads attribute bytes. It uses the idle access slots that the slower pixel rate leaves between bitmap reads. An attribute is read once, on the first pixel row of a character row, and is kept in an on-block line buffer for the seven rows that follow. Each bitmap bit then picks a foreground or background colour from the attribute. One attribute can serve one, two or four columns. Every line starts with eight black cycles, so the first column's bitmap and attribute can be read before that column is shown.

The caller pulses `line_start` once per scanline with the mode, the line-active flag and the first-row flag set. The block issues one read request at a time and expects the byte on `rdata` in the cycle after the request.

Top module: `attr_pixel_ser`

## Requirements
- R1: While `rst_n` is low, and after reset until the first `line_start`, `pix_rgb` is 0 and `fetch_req` is 0.
- R2: A `line_start` pulse latches `scale_sel`, `attr_sel`, `line_active` and `first_row`. The next 8 cycles are black. They are followed by exactly 640 pixel slots. After that the output stays black and no fetch is made until the next `line_start`.
- R3: Pixels leave each bitmap byte most significant bit first. Each bit is held for S cycles, where `scale_sel` 0 gives S=1, 1 gives S=2, and 2 or 3 gives S=3.
- R4: A line has 640/(8·S) columns (80, 40 or 26), with one bitmap fetch per column. At S=3 the slots after column 25 (the last 16) are black.
- R5: Bitmap fetches have `fetch_attr`=0 and `fetch_col` equal to the column index. They come in ascending column order and never in two consecutive cycles. The memory must drive the requested byte on `rdata` during the cycle after a request.
- R6: Attribute fetches (`fetch_attr`=1) happen only on lines with `first_row`=1, `attr_sel`≠0 and S>1. One attribute is fetched per group of 1, 2 or 4 columns (`attr_sel` 1, 2, 3), with `fetch_col` = column/group size. That gives ceil(columns/group) fetches per line.
- R7: Lines with `first_row`=0 colour their pixels with the attributes stored by the most recent attribute fetch of each index.
- R8: With `attr_sel`=1, a set bit gives `pix_rgb`=attribute[6:4] and a clear bit gives attribute[2:0].
- R9: With `attr_sel`=2, even columns use attribute[6:4] and odd columns use attribute[2:0] as the colour of set bits. Clear bits are black.
- R10: With `attr_sel`=3, column c uses the 2-bit field at attribute bits [7−2j:6−2j], where j=c mod 4. A set bit gives `pix_rgb`={field,1}. A clear bit is black.
- R11: With `attr_sel`=0 or S=1, set bits are white (`pix_rgb`=3'b111, bit order {R,G,B}) and clear bits are black.
- R12: On a line with `line_active`=0 the output is black for the whole line, no fetch is made, and the stored attributes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse that starts a scanline and latches the mode |
| scale_sel | input | 2 | Horizontal scale: 0 x1, 1 x2, 2/3 x3 |
| attr_sel | input | 2 | Attribute sharing: 0 none, 1 per column, 2 per pair, 3 per quad |
| line_active | input | 1 | Line lies in the displayed region |
| first_row | input | 1 | Line is the first pixel row of a character row |
| rdata | input | 8 | Read data, valid in the cycle after a request |
| fetch_req | output | 1 | Read request this cycle |
| fetch_attr | output | 1 | Request is for an attribute byte (else bitmap) |
| fetch_col | output | 7 | Column index for bitmap fetches, attribute index for attribute fetches |
| pix_rgb | output | 3 | Pixel colour {R,G,B} |

## Verification
Lines are run in plain monochrome at x1 and x2, and with per-column, per-pair and per-quad attributes at x2 and x3, using byte values that differ by column and by line. This separates the nibble and field selection in the colour decode, catches a wrong bit order, and catches a wrong hold length in the scale counter. Rows with the first-row flag cleared are served from memory contents that have changed since the fetching row, so a design that refetches attributes or indexes the buffer wrongly shows the wrong colours. An inactive first-row line placed before a reuse line shows that the buffer was left untouched. Request counts and bitmap column order are checked on every line, and so are the x3 padding and the black lead-in and tail.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

   typedef enum logic [1:0] {
      AT_NONE = 2'd0,
      AT_COL  = 2'd1,
      AT_PAIR = 2'd2,
      AT_QUAD = 2'd3
   } attr_e;

   localparam int BYTE_PIX = 8;

   // Colour of one pixel from its bitmap bit and the attribute in force.
   function automatic logic [2:0] colour_of(input logic  bit_v,
                                            input logic  mono,
                                            input attr_e am,
                                            input logic [7:0] a,
                                            input logic [1:0] pos);
      logic [2:0] nib;
      logic [1:0] fld;
      nib = pos[0] ? a[2:0] : a[6:4];
      case (pos)
         2'd0:    fld = a[7:6];
         2'd1:    fld = a[5:4];
         2'd2:    fld = a[3:2];
         default: fld = a[1:0];
      endcase
      if (mono)
         return bit_v ? 3'b111 : 3'b000;
      case (am)
         AT_COL:  return bit_v ? a[6:4] : a[2:0];
         AT_PAIR: return bit_v ? nib : 3'b000;
         default: return bit_v ? {fld, 1'b1} : 3'b000;
      endcase
   endfunction

endpackage

// File: rtl/pxs_seq.sv
module pxs_seq
   import pxs_pkg::*;
#(
   parameter int LINE_SLOTS = 640,
   parameter int COL_W      = 7,
   parameter int PSL_W      = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic [1:0]       scale_i,
   input  attr_e            attr_i,
   input  logic             act_i,
   input  logic             first_i,
   output logic             running,
   output logic             in_lead,
   output logic             pad,
   output logic [2:0]       k,
   output logic [1:0]       rep,
   output logic [1:0]       scale_q,
   output attr_e            attr_q,
   output logic             act_q,
   output logic             first_q,
   output logic             step,
   output logic             boundary,
   output logic [COL_W-1:0] next_col,
   output logic             next_ok
);

   localparam int NC1 = LINE_SLOTS / (BYTE_PIX * 1);
   localparam int NC2 = LINE_SLOTS / (BYTE_PIX * 2);
   localparam int NC3 = LINE_SLOTS / (BYTE_PIX * 3);

   logic [COL_W-1:0] col;
   logic [COL_W-1:0] last_col;
   logic [PSL_W-1:0] psl;
   logic [1:0]       rep_max;
   logic             rep_last;

   always_comb begin
      case (scale_q)
         2'd0:    begin last_col = COL_W'(NC1 - 1); rep_max = 2'd0; end
         2'd1:    begin last_col = COL_W'(NC2 - 1); rep_max = 2'd1; end
         default: begin last_col = COL_W'(NC3 - 1); rep_max = 2'd2; end
      endcase
      rep_last = in_lead || (rep == rep_max);
      step     = running && rep_last;
      boundary = step && (k == 3'd7);
      next_col = in_lead ? '0 : COL_W'(col + 1'b1);
      next_ok  = running && !pad && (in_lead || (col != last_col));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         in_lead <= 1'b0;
         pad     <= 1'b0;
         k       <= '0;
         rep     <= '0;
         col     <= '0;
         psl     <= '0;
         scale_q <= '0;
         attr_q  <= AT_NONE;
         act_q   <= 1'b0;
         first_q <= 1'b0;
      end else if (line_start) begin
         running <= 1'b1;
         in_lead <= 1'b1;
         pad     <= 1'b0;
         k       <= '0;
         rep     <= '0;
         col     <= '0;
         psl     <= '0;
         scale_q <= scale_i;
         attr_q  <= attr_i;
         act_q   <= act_i;
         first_q <= first_i;
      end else if (running) begin
         if (rep_last) begin
            rep <= '0;
            k   <= 3'(k + 3'd1);
         end else begin
            rep <= 2'(rep + 2'd1);
         end
         if (boundary) begin
            if (in_lead) begin
               in_lead <= 1'b0;
               col     <= '0;
            end else if (col == last_col) begin
               pad <= 1'b1;
            end else begin
               col <= COL_W'(col + 1'b1);
            end
         end
         if (!in_lead) begin
            psl <= PSL_W'(psl + 1'b1);
            if (psl == PSL_W'(LINE_SLOTS - 1))
               running <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pxs_fetch.sv
module pxs_fetch
   import pxs_pkg::*;
#(
   parameter int COL_W      = 7,
   parameter int ATTR_DEPTH = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic [2:0]       k,
   input  logic [1:0]       rep,
   input  logic [COL_W-1:0] next_col,
   input  logic             next_ok,
   input  logic             act_q,
   input  logic             first_q,
   input  attr_e            attr_q,
   input  logic [1:0]       scale_q,
   input  logic [7:0]       rdata,
   output logic             fetch_req,
   output logic             fetch_attr,
   output logic [COL_W-1:0] fetch_col,
   output logic [7:0]       bm_stage,
   output logic [7:0]       attr_rd
);

   localparam int AW = (ATTR_DEPTH > 1) ? $clog2(ATTR_DEPTH) : 1;
   localparam logic [2:0] SLOT_ATTR = 3'd4;
   localparam logic [2:0] SLOT_BMAP = 3'd5;

   logic [1:0]       shamt;
   logic             need_a;
   logic             attr_en;
   logic             idx_ok;
   logic             req_a;
   logic             req_b;
   logic [COL_W-1:0] aidx;
   logic             pend_a;
   logic             pend_b;
   logic [AW-1:0]    pend_idx;
   logic [7:0]       ent [ATTR_DEPTH];

   always_comb begin
      case (attr_q)
         AT_PAIR: begin shamt = 2'd1; need_a = !next_col[0]; end
         AT_QUAD: begin shamt = 2'd2; need_a = (next_col[1:0] == 2'b00); end
         default: begin shamt = 2'd0; need_a = 1'b1; end
      endcase
      aidx    = next_col >> shamt;
      idx_ok  = (int'(aidx) < ATTR_DEPTH);
      attr_en = act_q && first_q && (attr_q != AT_NONE) && (scale_q != 2'd0);
      req_a   = running && (k == SLOT_ATTR) && (rep == 2'd0) && next_ok
                && attr_en && need_a && idx_ok;
      req_b   = running && (k == SLOT_BMAP) && (rep == 2'd0) && next_ok && act_q;
      fetch_req  = req_a || req_b;
      fetch_attr = req_a;
      fetch_col  = req_a ? aidx : next_col;
      attr_rd    = idx_ok ? ent[aidx[AW-1:0]] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_a   <= 1'b0;
         pend_b   <= 1'b0;
         pend_idx <= '0;
         bm_stage <= '0;
      end else begin
         pend_a   <= req_a;
         pend_b   <= req_b;
         pend_idx <= aidx[AW-1:0];
         if (pend_b)
            bm_stage <= rdata;
      end
   end

   // One register per attribute column, written when its fetch returns.
   for (genvar i = 0; i < ATTR_DEPTH; i++) begin : g_ent
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (pend_a && (pend_idx == AW'(i)))
            q <= rdata;
      end
      assign ent[i] = q;
   end

endmodule

// File: rtl/pxs_shift.sv
module pxs_shift
   import pxs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       running,
   input  logic       in_lead,
   input  logic       pad,
   input  logic       act_q,
   input  attr_e      attr_q,
   input  logic [1:0] scale_q,
   input  logic       step,
   input  logic       boundary,
   input  logic       next_ok,
   input  logic [1:0] next_pos,
   input  logic [7:0] bm_stage,
   input  logic [7:0] attr_rd,
   output logic [2:0] pix_rgb
);

   logic [7:0] sh;
   logic [7:0] cur_attr;
   logic [1:0] pos;
   logic       disp;
   logic       mono;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         cur_attr <= '0;
         pos      <= '0;
      end else if (boundary && next_ok) begin
         sh       <= bm_stage;
         cur_attr <= attr_rd;
         pos      <= next_pos;
      end else if (step && !in_lead) begin
         sh <= {sh[6:0], 1'b0};
      end
   end

   always_comb begin
      disp    = running && !in_lead && !pad && act_q;
      mono    = (attr_q == AT_NONE) || (scale_q == 2'd0);
      pix_rgb = disp ? colour_of(sh[7], mono, attr_q, cur_attr, pos) : 3'b000;
   end

endmodule

// File: rtl/attr_pixel_ser.sv
module attr_pixel_ser
   import pxs_pkg::*;
#(
   parameter int  LINE_SLOTS = 640,
   parameter int  ATTR_DEPTH = 40,
   localparam int COL_W      = $clog2(LINE_SLOTS / BYTE_PIX),
   localparam int PSL_W      = $clog2(LINE_SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic [1:0]       scale_sel,
   input  logic [1:0]       attr_sel,
   input  logic             line_active,
   input  logic             first_row,
   input  logic [7:0]       rdata,
   output logic             fetch_req,
   output logic             fetch_attr,
   output logic [COL_W-1:0] fetch_col,
   output logic [2:0]       pix_rgb
);

   if (LINE_SLOTS % (2 * BYTE_PIX) != 0) begin : g_bad_slots
      $error("LINE_SLOTS must be a multiple of 16");
   end
   if (ATTR_DEPTH < LINE_SLOTS / (2 * BYTE_PIX)) begin : g_bad_depth
      $error("ATTR_DEPTH must cover every x2 column");
   end

   logic             running, in_lead, pad;
   logic [2:0]       k;
   logic [1:0]       rep;
   logic [1:0]       scale_q;
   attr_e            attr_q;
   logic             act_q, first_q;
   logic             step, boundary, next_ok;
   logic [COL_W-1:0] next_col;
   logic [7:0]       bm_stage, attr_rd;

   pxs_seq #(
      .LINE_SLOTS(LINE_SLOTS),
      .COL_W     (COL_W),
      .PSL_W     (PSL_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_start(line_start),
      .scale_i   (scale_sel),
      .attr_i    (attr_e'(attr_sel)),
      .act_i     (line_active),
      .first_i   (first_row),
      .running   (running),
      .in_lead   (in_lead),
      .pad       (pad),
      .k         (k),
      .rep       (rep),
      .scale_q   (scale_q),
      .attr_q    (attr_q),
      .act_q     (act_q),
      .first_q   (first_q),
      .step      (step),
      .boundary  (boundary),
      .next_col  (next_col),
      .next_ok   (next_ok)
   );

   pxs_fetch #(
      .COL_W     (COL_W),
      .ATTR_DEPTH(ATTR_DEPTH)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .running   (running),
      .k         (k),
      .rep       (rep),
      .next_col  (next_col),
      .next_ok   (next_ok),
      .act_q     (act_q),
      .first_q   (first_q),
      .attr_q    (attr_q),
      .scale_q   (scale_q),
      .rdata     (rdata),
      .fetch_req (fetch_req),
      .fetch_attr(fetch_attr),
      .fetch_col (fetch_col),
      .bm_stage  (bm_stage),
      .attr_rd   (attr_rd)
   );

   pxs_shift u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .running (running),
      .in_lead (in_lead),
      .pad     (pad),
      .act_q   (act_q),
      .attr_q  (attr_q),
      .scale_q (scale_q),
      .step    (step),
      .boundary(boundary),
      .next_ok (next_ok),
      .next_pos(next_col[1:0]),
      .bm_stage(bm_stage),
      .attr_rd (attr_rd),
      .pix_rgb (pix_rgb)
   );

endmodule

// File: rtl/attr_pixel_ser_chk.sv
module attr_pixel_ser_chk #(
   parameter int LINE_SLOTS = 640,
   parameter int COL_W      = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fetch_req,
   input logic             fetch_attr,
   input logic [COL_W-1:0] fetch_col,
   input logic [2:0]       pix_rgb,
   input logic             running,
   input logic             in_lead,
   input logic             pad,
   input logic             act_q,
   input logic             first_q
);

   AST_LEAD_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      in_lead |-> (pix_rgb == 3'b000));                              // R2
   AST_IDLE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !fetch_req);                                      // R2
   AST_PAD_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      pad |-> (pix_rgb == 3'b000));                                  // R4
   AST_BMAP_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_attr) |-> (int'(fetch_col) < LINE_SLOTS / 8)); // R4
   AST_BMAP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !fetch_attr) |=> !(fetch_req && !fetch_attr));   // R5
   AST_ATTR_FIRST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_attr) |-> first_q);                        // R6
   AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q |-> (!fetch_req && pix_rgb == 3'b000));                 // R12

endmodule

bind attr_pixel_ser attr_pixel_ser_chk #(
   .LINE_SLOTS(LINE_SLOTS),
   .COL_W     (COL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fetch_req (fetch_req),
   .fetch_attr(fetch_attr),
   .fetch_col (fetch_col),
   .pix_rgb   (pix_rgb),
   .running   (running),
   .in_lead   (in_lead),
   .pad       (pad),
   .act_q     (act_q),
   .first_q   (first_q)
);

// File: tb/attr_pixel_ser_tb.sv
module attr_pixel_ser_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_start = 1'b0;
   logic [1:0] scale_sel = 2'd0;
   logic [1:0] attr_sel = 2'd0;
   logic       line_active = 1'b0;
   logic       first_row = 1'b0;
   logic [7:0] rdata = 8'h00;
   logic       fetch_req, fetch_attr;
   logic [6:0] fetch_col;
   logic [2:0] pix_rgb;

   int checks = 0;
   int failures = 0;
   int cur_line = 0;
   int exp_attr [40];
   bit done = 1'b0;

   attr_pixel_ser u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .scale_sel  (scale_sel),
      .attr_sel   (attr_sel),
      .line_active(line_active),
      .first_row  (first_row),
      .rdata      (rdata),
      .fetch_req  (fetch_req),
      .fetch_attr (fetch_attr),
      .fetch_col  (fetch_col),
      .pix_rgb    (pix_rgb)
   );

   always #5 clk = ~clk;

   function automatic int bm_of(input int c, input int l);
      return (c * 37 + l * 11 + 90) & 255;
   endfunction

   function automatic int at_of(input int i, input int l);
      return (i * 29 + l * 53 + 3) & 255;
   endfunction

   // Memory model: answers each request in the following cycle.
   initial begin
      bit pend = 1'b0;
      bit pa = 1'b0;
      int pc = 0;
      forever begin
         @(negedge clk);
         if (pend) rdata = 8'(pa ? at_of(pc, cur_line) : bm_of(pc, cur_line));
         pend = fetch_req;
         pa   = fetch_attr;
         pc   = int'(fetch_col);
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_pix(input int p, input int s, input int ncol, input int am,
                                  input bit mono, input bit act);
      int c, b, bv, share, a, j;
      c = p / (8 * s);
      if (!act || c >= ncol) return 0;
      b  = (p % (8 * s)) / s;
      bv = (bm_of(c, cur_line) >> (7 - b)) & 1;
      if (mono) return bv ? 7 : 0;
      share = (am == 1) ? 1 : (am == 2) ? 2 : 4;
      a = exp_attr[c / share];
      if (am == 1) return bv ? ((a >> 4) & 7) : (a & 7);
      if (am == 2) return bv ? (((c % 2) == 0) ? ((a >> 4) & 7) : (a & 7)) : 0;
      j = c % 4;
      return bv ? ((((a >> (6 - 2 * j)) & 3) << 1) | 1) : 0;
   endfunction

   // One scanline; checks framing, pixels, fetch counts and order.
   task automatic run_line(input int sc, input int am, input bit act, input bit first,
                           input string tag);
      int  s, ncol, share, n_attr;
      bit  mono;
      int  bm_seen = 0, at_seen = 0, col_bad = 0, lead_bad = 0, idle_bad = 0;
      int  pix_bad = 0, fa = 0, fe = 0;
      cur_line++;
      s      = (sc == 0) ? 1 : (sc == 1) ? 2 : 3;
      ncol   = 640 / (8 * s);
      mono   = (am == 0) || (sc == 0);
      share  = (am == 1) ? 1 : (am == 2) ? 2 : 4;
      n_attr = (act && first && !mono) ? (ncol + share - 1) / share : 0;
      for (int i = 0; i < n_attr; i++) exp_attr[i] = at_of(i, cur_line);
      @(negedge clk);
      scale_sel = 2'(sc); attr_sel = 2'(am);
      line_active = act; first_row = first; line_start = 1'b1;
      @(negedge clk);
      line_start = 1'b0;
      for (int i = 0; i < 652; i++) begin
         if (fetch_req) begin
            if (fetch_attr) at_seen++;
            else begin
               if (int'(fetch_col) != bm_seen) col_bad++;
               bm_seen++;
            end
         end
         if (i < 8) begin
            if (pix_rgb != 3'b000) lead_bad++;
         end else if (i < 648) begin
            int e;
            e = exp_pix(i - 8, s, ncol, am, mono, act);
            if (int'(pix_rgb) != e) begin
               if (pix_bad == 0) begin fa = int'(pix_rgb); fe = e; end
               pix_bad++;
            end
         end else if (pix_rgb != 3'b000 || fetch_req) begin
            idle_bad++;
         end
         @(negedge clk);
      end
      chk(lead_bad == 0, {"R2 lead-in black ", tag}, lead_bad, 0);
      chk(pix_bad == 0, {"R3 pixel stream ", tag}, fa, fe);
      chk(bm_seen == (act ? ncol : 0), {"R4 bitmap fetch count ", tag}, bm_seen, act ? ncol : 0);
      chk(col_bad == 0, {"R5 bitmap order ", tag}, col_bad, 0);
      chk(at_seen == n_attr, {"R6 attribute fetch count ", tag}, at_seen, n_attr);
      chk(idle_bad == 0, {"R2 tail quiet ", tag}, idle_bad, 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(pix_rgb == 3'b000, "R1 black in reset", int'(pix_rgb), 0);
      chk(!fetch_req, "R1 no fetch in reset", int'(fetch_req), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(pix_rgb == 3'b000 && !fetch_req, "R1 idle after reset",
          int'({fetch_req, pix_rgb}), 0);
   endtask

   task automatic t_mono_x1();       run_line(0, 0, 1, 1, "R11 mono x1");            endtask
   task automatic t_full_x2();       run_line(1, 1, 1, 1, "R8 per-column x2");       endtask
   task automatic t_full_x2_reuse(); run_line(1, 1, 1, 0, "R7 per-column reuse");    endtask
   task automatic t_pair_x2();       run_line(1, 2, 1, 1, "R9 pair x2");             endtask
   task automatic t_quad_x3();       run_line(2, 3, 1, 1, "R10 quad x3 R4 pad");     endtask
   task automatic t_quad_x3_reuse(); run_line(2, 3, 1, 0, "R7 quad reuse");          endtask
   task automatic t_full_x3();       run_line(3, 1, 1, 1, "R8 per-column x3");       endtask
   task automatic t_attr_x1();       run_line(0, 1, 1, 1, "R11 attr ignored at x1"); endtask
   task automatic t_inactive();      run_line(1, 1, 0, 1, "R12 inactive line");      endtask
   task automatic t_after_inact();   run_line(1, 1, 1, 0, "R12 buffer kept R7");     endtask
   task automatic t_mono_x2();       run_line(1, 0, 1, 1, "R11 mono x2");            endtask

   initial begin
      for (int i = 0; i < 40; i++) exp_attr[i] = 0;
      t_reset();
      t_mono_x1();
      t_full_x2();
      t_full_x2_reuse();
      t_pair_x2();
      t_quad_x3();
      t_quad_x3_reuse();
      t_full_x3();
      t_attr_x1();
      t_inactive();
      t_after_inact();
      t_mono_x2();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #5000000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule